// File: doc/BRIEF.md
# Condition Register Field Move Unit

This unit moves data between a 64-bit general-purpose register value, four status bits from the fixed-point exception register (overflow, 32-bit overflow, carry, 32-bit carry) and a 32-bit condition register made of eight 4-bit fields. It holds the condition register itself and a registered destination value, and performs one operation per clock cycle, chosen by a 3-bit operation code.

There are four operations.
- A masked field write: an 8-bit field mask is expanded into 4-bit lanes, and the low 32 bits of the source are merged into the condition register.
- A full read: the destination receives the condition register, zero-extended to 64 bits.
- A status pack: the four exception bits are copied into one selected field.
- A set-boolean: one selected field is turned into -1, +1 or 0 in the destination.

Both registers update on the rising clock edge. A read or set-boolean issued in one cycle therefore sees every condition-register change made by the operation in the cycle before it.

Top module: `cr_field_mover`

## Requirements
- R1: While `rst_n` is low at a rising edge, `cr_o` becomes 0 and `dst_o` becomes 0.
- R2: Operation code 1 (field write) makes the next `cr_o` equal to `(src_i[31:0] & M) | (old cr_o & ~M)`, where M is the expanded field mask.
- R3: Mask bit `fxm_i[j]` covers `cr_o[4j+3:4j]`. Bit 7 therefore selects field 0, which is the most significant nibble `cr_o[31:28]`.
- R4: A field write with `fxm_i` equal to 0 leaves `cr_o` unchanged.
- R5: Operation code 2 (full read) makes the next `dst_o` equal to `{32'h0, cr_o}`.
- R6: Operation code 3 (status pack) writes `{ov_i, ov32_i, ca_i, ca32_i}`, most significant first, into field `fld_i`. Field f occupies `cr_o[31-4f:28-4f]`. All other fields keep their values.
- R7: Operation code 4 (set-boolean) makes the next `dst_o` all ones when the top bit of field `fld_i` (`cr_o[31-4f]`) is set.
- R8: Set-boolean returns 1 when the top bit of the field is clear and its second bit (`cr_o[30-4f]`) is set, and returns 0 when both are clear.
- R9: Operation code 0 and the unused codes 5 to 7 change neither output. Only codes 1 and 3 change `cr_o`, and only codes 2 and 4 change `dst_o`.
- R10: A full read or set-boolean in the cycle right after a write or pack observes the value that write or pack produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code: 0 none, 1 field write, 2 full read, 3 status pack, 4 set-boolean |
| src_i | input | 64 | Source general-register value |
| fxm_i | input | 8 | Field mask for the field write |
| fld_i | input | 3 | Field index for pack and set-boolean, 0 is the top field |
| ov_i | input | 1 | Overflow status bit |
| ov32_i | input | 1 | 32-bit overflow status bit |
| ca_i | input | 1 | Carry status bit |
| ca32_i | input | 1 | 32-bit carry status bit |
| cr_o | output | 32 | Condition register |
| dst_o | output | 64 | Registered destination value |

## Verification
A condition-register update and a read of that register land on the same clock edge when a write or pack is immediately followed by a full read or set-boolean. The edge that commits the new field is then the edge that starts the read. The bench provokes this with back-to-back pairs on the same field, and with a random stream in which such pairs occur often. A behavioural model in the bench applies each operation in program order and compares both outputs after every edge, so a read that returned the stale value would show up as a mismatch.

// File: rtl/crmv_pkg.sv
// Package: shared constants and operation codes for the condition register
// field move unit. Assumes a fixed 4-bit field width.
package crmv_pkg;
    localparam int LANE_W = 4;

    typedef enum logic [2:0] {
        CRMV_NOP   = 3'd0,
        CRMV_WRITE = 3'd1,
        CRMV_READ  = 3'd2,
        CRMV_PACK  = 3'd3,
        CRMV_BOOL  = 3'd4
    } crmv_op_e;
endpackage

// File: rtl/crmv_lane_mask.sv
// Expands a per-field mask into a per-bit mask. Mask bit j covers bits
// [4j+3:4j], so the top mask bit selects the most significant field.
// Assumes LANE_W bits per field.
module crmv_lane_mask #(
    parameter int FIELDS = 8
) (
    input  logic [FIELDS-1:0]                  fxm_i,
    output logic [FIELDS*crmv_pkg::LANE_W-1:0] mask_o
);
    // one replicated lane per mask bit
    for (genvar j = 0; j < FIELDS; j++) begin : g_lane
        assign mask_o[j*crmv_pkg::LANE_W +: crmv_pkg::LANE_W] = {crmv_pkg::LANE_W{fxm_i[j]}};
    end
endmodule

// File: rtl/crmv_field_pick.sv
// Selects one field of the condition register. Index 0 is the most
// significant field. Assumes FIELDS is a power of two.
module crmv_field_pick #(
    parameter int FIELDS = 8,
    localparam int IDX_W = $clog2(FIELDS),
    localparam int CR_W  = FIELDS * crmv_pkg::LANE_W
) (
    input  logic [CR_W-1:0]            cr_i,
    input  logic [IDX_W-1:0]           idx_i,
    output logic [crmv_pkg::LANE_W-1:0] fld_o
);
    // multiplexer over the fields, counted from the top
    always_comb begin
        fld_o = '0;
        for (int f = 0; f < FIELDS; f++) begin
            if (idx_i == IDX_W'(f))
                fld_o = cr_i[(FIELDS-1-f)*crmv_pkg::LANE_W +: crmv_pkg::LANE_W];
        end
    end
endmodule

// File: rtl/crmv_bool_gen.sv
// Turns one condition field into a signed boolean value. If the top bit is
// set the result is -1; otherwise, if the second bit is set, it is +1;
// otherwise it is 0.
module crmv_bool_gen #(
    parameter int GPR_W = 64
) (
    input  logic [crmv_pkg::LANE_W-1:0] fld_i,
    output logic [GPR_W-1:0]            val_o
);
    // priority: top bit, then second bit
    always_comb begin
        if (fld_i[crmv_pkg::LANE_W-1])
            val_o = {GPR_W{1'b1}};
        else if (fld_i[crmv_pkg::LANE_W-2])
            val_o = {{(GPR_W-1){1'b0}}, 1'b1};
        else
            val_o = '0;
    end
endmodule

// File: rtl/cr_field_mover.sv
// Condition register field move unit. Holds the condition register and a
// registered destination value, and performs one operation per cycle:
// masked field write, full read, status pack, or set-boolean.
// Assumes GPR_W >= FIELDS*4 and a synchronous active-low reset.
module cr_field_mover #(
    parameter int GPR_W  = 64,
    parameter int FIELDS = 8,
    localparam int CR_W  = FIELDS * crmv_pkg::LANE_W,
    localparam int IDX_W = $clog2(FIELDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [GPR_W-1:0] src_i,
    input  logic [FIELDS-1:0] fxm_i,
    input  logic [IDX_W-1:0] fld_i,
    input  logic             ov_i,
    input  logic             ov32_i,
    input  logic             ca_i,
    input  logic             ca32_i,
    output logic [CR_W-1:0]  cr_o,
    output logic [GPR_W-1:0] dst_o
);
    import crmv_pkg::*;

    crmv_op_e                op;
    logic [CR_W-1:0]         cr_q, cr_d;
    logic [GPR_W-1:0]        dst_q, dst_d;
    logic [CR_W-1:0]         lane_mask;
    logic [LANE_W-1:0]       sel_field;
    logic [GPR_W-1:0]        bool_val;
    logic [LANE_W-1:0]       status;
    logic [GPR_W-CR_W-1:0]   src_hi_unused;

    assign op            = crmv_op_e'(op_i);
    assign status        = {ov_i, ov32_i, ca_i, ca32_i};
    assign src_hi_unused = src_i[GPR_W-1:CR_W];

    crmv_lane_mask #(.FIELDS(FIELDS)) i_mask (
        .fxm_i  (fxm_i),
        .mask_o (lane_mask)
    );

    crmv_field_pick #(.FIELDS(FIELDS)) i_pick (
        .cr_i  (cr_q),
        .idx_i (fld_i),
        .fld_o (sel_field)
    );

    crmv_bool_gen #(.GPR_W(GPR_W)) i_bool (
        .fld_i (sel_field),
        .val_o (bool_val)
    );

    // next condition register: merge write or single-field pack
    always_comb begin
        cr_d = cr_q;
        case (op)
            CRMV_WRITE: cr_d = (src_i[CR_W-1:0] & lane_mask) | (cr_q & ~lane_mask);
            CRMV_PACK: begin
                for (int f = 0; f < FIELDS; f++) begin
                    if (fld_i == IDX_W'(f))
                        cr_d[(FIELDS-1-f)*LANE_W +: LANE_W] = status;
                end
            end
            default: cr_d = cr_q;
        endcase
    end

    // next destination value: full read or set-boolean, otherwise hold
    always_comb begin
        case (op)
            CRMV_READ: dst_d = {{(GPR_W-CR_W){1'b0}}, cr_q};
            CRMV_BOOL: dst_d = bool_val;
            default:   dst_d = dst_q;
        endcase
    end

    // state registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q  <= '0;
            dst_q <= '0;
        end else begin
            cr_q  <= cr_d;
            dst_q <= dst_d;
        end
    end

    assign cr_o  = cr_q;
    assign dst_o = dst_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cr_q == '0 && dst_q == '0)); // R1

    AST_WRITE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> cr_q == (($past(src_i[CR_W-1:0]) & $past(lane_mask)) |
                                    ($past(cr_q) & ~$past(lane_mask)))); // R2

    AST_TOP_MASK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && fxm_i == {1'b1, {(FIELDS-1){1'b0}}})
        |=> cr_q[CR_W-LANE_W-1:0] == $past(cr_q[CR_W-LANE_W-1:0])); // R3

    AST_EMPTY_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && fxm_i == '0) |=> $stable(cr_q)); // R4

    AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> (dst_q == {{(GPR_W-CR_W){1'b0}}, $past(cr_q)})); // R5

    AST_PACK_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> ($countones(cr_q ^ $past(cr_q)) <= LANE_W)); // R6

    AST_BOOL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> (dst_q == '1 || dst_q == GPR_W'(1) || dst_q == '0)); // R8

    AST_CR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd1 && op_i != 3'd3) |=> $stable(cr_q)); // R9

    AST_DST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd2 && op_i != 3'd4) |=> $stable(dst_q)); // R9
endmodule

// File: tb/test_cr_field_mover.sv
module test_cr_field_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [63:0] src_i = '0;
    logic [7:0]  fxm_i = '0;
    logic [2:0]  fld_i = '0;
    logic        ov_i = 1'b0, ov32_i = 1'b0, ca_i = 1'b0, ca32_i = 1'b0;
    logic [31:0] cr_o;
    logic [63:0] dst_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_cr = '0;
    logic [63:0] m_dst = '0;

    always #5 clk = ~clk;

    cr_field_mover i_cr_field_mover (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_i(src_i), .fxm_i(fxm_i),
        .fld_i(fld_i), .ov_i(ov_i), .ov32_i(ov32_i), .ca_i(ca_i), .ca32_i(ca32_i),
        .cr_o(cr_o), .dst_o(dst_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model of one operation
    task automatic model(input int op);
        int top;
        top = 31 - 4 * int'(fld_i);
        case (op)
            1: for (int b = 0; b < 32; b++) if (fxm_i[b / 4]) m_cr[b] = src_i[b];
            2: m_dst = {32'h0, m_cr};
            3: begin
                m_cr[top] = ov_i; m_cr[top-1] = ov32_i;
                m_cr[top-2] = ca_i; m_cr[top-3] = ca32_i;
            end
            4: begin
                if (m_cr[top]) m_dst = '1;
                else if (m_cr[top-1]) m_dst = 64'd1;
                else m_dst = 64'd0;
            end
            default: ;
        endcase
    endtask

    task automatic step(input int op, input logic [63:0] src, input logic [7:0] fxm,
                        input int fld, input logic [3:0] st, input string tag);
        @(negedge clk);
        op_i = 3'(op); src_i = src; fxm_i = fxm; fld_i = 3'(fld);
        {ov_i, ov32_i, ca_i, ca32_i} = st;
        @(posedge clk);
        #1;
        model(op);
        check({tag, " cr"}, {32'h0, cr_o}, {32'h0, m_cr});
        check({tag, " dst"}, dst_o, m_dst);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 cr", {32'h0, cr_o}, 64'h0);
        check("R1 dst", dst_o, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 full and partial merges
        step(1, 64'hDEAD_BEEF_1234_5678, 8'hFF, 0, 4'h0, "R2");
        step(1, 64'h0000_0000_AAAA_AAAA, 8'h5A, 0, 4'h0, "R2");
        // R3 top mask bit hits the top nibble, bottom bit the bottom nibble
        step(1, 64'h0000_0000_F000_000F, 8'h80, 0, 4'h0, "R3");
        step(1, 64'h0000_0000_0000_0003, 8'h01, 0, 4'h0, "R3");
        check("R3 top nibble", {60'h0, cr_o[31:28]}, 64'hF);
        // R4 empty mask
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 0, 4'h0, "R4");
        // R5 full read, upper half zero
        step(2, 64'hFFFF_FFFF_0000_0000, 8'hFF, 0, 4'h0, "R5");
        check("R5 upper", {32'h0, dst_o[63:32]}, 64'h0);
        // R6 pack each field with distinct status
        for (int f = 0; f < 8; f++) step(3, '0, 8'h00, f, 4'(f * 5 + 3), "R6");
        // R7 / R8 set-boolean cases, each a write followed directly by a read (R10)
        step(3, '0, 8'h00, 2, 4'b1000, "R6");
        step(4, '0, 8'h00, 2, 4'h0, "R7 R10");
        check("R7 value", dst_o, '1);
        step(3, '0, 8'h00, 5, 4'b0111, "R6");
        step(4, '0, 8'h00, 5, 4'h0, "R8 one R10");
        check("R8 one", dst_o, 64'd1);
        step(1, 64'h0, 8'h08, 0, 4'h0, "R2");
        step(4, '0, 8'h00, 4, 4'h0, "R8 zero R10");
        check("R8 zero", dst_o, 64'd0);
        step(4, '0, 8'h00, 2, 4'h0, "R7");
        // R9 quiet codes
        for (int c = 5; c < 8; c++) step(c, '1, 8'hFF, 3, 4'hF, "R9");
        step(0, '1, 8'hFF, 3, 4'hF, "R9");
        step(1, 64'h0000_0000_1357_9BDF, 8'hC3, 0, 4'h0, "R2");
        step(2, '0, 8'h00, 0, 4'h0, "R10");
        // random stream with many back-to-back pairs
        for (int k = 0; k < 400; k++)
            step(int'($urandom_range(0, 7)), {$urandom, $urandom}, 8'($urandom),
                 int'($urandom_range(0, 7)), 4'($urandom), "R10 random");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule